// File: doc/BRIEF.md
# DDR2 Bank Timing Checker

This block watches the command stream a controller sends to a four-bank DDR2 SDRAM and judges each command against the row-timing rules of the bank it addresses. For every command presented on a clock it raises a combinational "legal now" flag. When a command breaks a rule, it latches a sticky violation flag together with a code that names the broken rule. It keeps one open/closed state and one set of down-counters per bank, plus one global counter for the all-bank precharge window.

Every timing limit is given as a minimum in picoseconds. It is turned into clock cycles at elaboration by ceiling division by the clock period. A single parameter switches the row-active minimum between the older and the newer part generation. With posted CAS, a READ or WRITE may be issued up to the additive latency earlier than the plain activate-to-access delay allows. The block reports when data is due on the bus: a read strobe after AL+CL cycles and a write strobe one cycle earlier than that.

The block is meant to sit next to a controller or a bus monitor in simulation and in silicon. It blocks nothing and alters nothing. It only judges.

Top module: `ddr2_bank_guard`

## Requirements
- R1: While reset is held and right after it, every bank is closed, `viol_sticky`, `viol_code`, `rd_due` and `wr_due` are 0, and no timing window is pending.
- R2: `cmd_op` encodes NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4, PRECHARGE-ALL=5. Values 6 and 7 act as NOP, and a NOP is always legal.
- R3: A READ or WRITE to a closed bank is illegal with code 6. To an open bank it is illegal with code 1 unless at least max(tRCD_cycles−AL, 1) cycles have passed since that bank's ACTIVATE.
- R4: An ACTIVATE to a bank that is already open is illegal with code 7.
- R5: A PRECHARGE to an open bank is illegal with code 3 until tRAS cycles have passed since its ACTIVATE. A PRECHARGE to a closed bank is legal and changes nothing.
- R6: An ACTIVATE to a closed bank is illegal with code 2 until tRP cycles have passed since that bank was precharged.
- R7: An ACTIVATE is illegal with code 4 until tRC cycles have passed since the previous ACTIVATE to the same bank.
- R8: A PRECHARGE-ALL is illegal with code 3 if any open bank has not yet met tRAS. A legal one closes every bank, and no ACTIVATE to any bank is then legal for tPREA cycles (code 5). When several ACTIVATE rules fail at once, the code chosen follows the priority 7, 5, 2, 4.
- R9: Each cycle count is ceil(minimum_ps / CLK_PS). tRAS uses 45000 ps, or 40000 ps when NEWER_PARTS is 1. At the default 5000 ps period this gives tRCD=tRP=tPREA=3, tRC=12, and tRAS=9 or 8.
- R10: An illegal command changes no bank state and no counter, and it starts no data strobe.
- R11: `viol_sticky` rises in the cycle after the first illegal command, and `viol_code` then holds that command's code until reset. Later violations do not change it.
- R12: `rd_due` is high exactly AL+CL cycles after a legal READ, and `wr_due` is high exactly AL+CL−1 cycles after a legal WRITE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | Command code presented this cycle |
| cmd_bank | input | $clog2(BANKS) | Bank the command addresses |
| cmd_legal | output | 1 | The presented command satisfies every rule now |
| viol_sticky | output | 1 | A violation has occurred since reset |
| viol_code | output | 3 | Rule broken by the first violation |
| rd_due | output | 1 | Read data is due on the bus this cycle |
| wr_due | output | 1 | Write data is due on the bus this cycle |

## Verification
The assertions assume that every command value on `cmd_op` is sampled as issued in the cycle it is presented, and that `cmd_bank` always names an existing bank. The stimulus drives one command per cycle between falling edges and returns to NOP after each rising edge, so no command is ever counted twice. Each rule violation is provoked in a run of its own after a fresh reset. Because the sticky code keeps only the first violation, this way every code can be observed.

// File: rtl/ddr2_guard_pkg.sv
package ddr2_guard_pkg;

   localparam logic [2:0] OP_NOP  = 3'd0;
   localparam logic [2:0] OP_ACT  = 3'd1;
   localparam logic [2:0] OP_RD   = 3'd2;
   localparam logic [2:0] OP_WR   = 3'd3;
   localparam logic [2:0] OP_PRE  = 3'd4;
   localparam logic [2:0] OP_PREA = 3'd5;

   typedef enum logic [2:0] {
      V_NONE   = 3'd0,
      V_RCD    = 3'd1,
      V_RP     = 3'd2,
      V_RAS    = 3'd3,
      V_RC     = 3'd4,
      V_PREA   = 3'd5,
      V_CLOSED = 3'd6,
      V_OPEN   = 3'd7
   } viol_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   // counters load cycles-1 so the command is legal exactly 'cyc' cycles later
   function automatic int load_of(input int cyc);
      return (cyc > 1) ? cyc - 1 : 0;
   endfunction

endpackage

// File: rtl/ddr2_bank_timer.sv
module ddr2_bank_timer #(
   parameter int RCD_LD = 2,
   parameter int RP_LD  = 2,
   parameter int RAS_LD = 8,
   parameter int RC_LD  = 11,
   parameter int CW     = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act,
   input  logic close,
   output logic is_open,
   output logic rcd_ok,
   output logic rp_ok,
   output logic ras_ok,
   output logic rc_ok
);

   logic [CW-1:0] rcd_cnt, rp_cnt, ras_cnt, rc_cnt;

   function automatic logic [CW-1:0] sat_dec(input logic [CW-1:0] v);
      return (v == '0) ? v : v - 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         is_open <= 1'b0;
         rcd_cnt <= '0;
         rp_cnt  <= '0;
         ras_cnt <= '0;
         rc_cnt  <= '0;
      end else begin
         if (act)
            is_open <= 1'b1;
         else if (close)
            is_open <= 1'b0;
         rcd_cnt <= act   ? CW'(RCD_LD) : sat_dec(rcd_cnt);
         ras_cnt <= act   ? CW'(RAS_LD) : sat_dec(ras_cnt);
         rc_cnt  <= act   ? CW'(RC_LD)  : sat_dec(rc_cnt);
         rp_cnt  <= close ? CW'(RP_LD)  : sat_dec(rp_cnt);
      end
   end

   assign rcd_ok = (rcd_cnt == '0);
   assign rp_ok  = (rp_cnt  == '0);
   assign ras_ok = (ras_cnt == '0);
   assign rc_ok  = (rc_cnt  == '0);

endmodule

// File: rtl/ddr2_due_pipe.sv
module ddr2_due_pipe #(
   parameter int DEPTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic due
);

   generate
      if (DEPTH == 1) begin : g_single
         logic stage;
         always_ff @(posedge clk) begin
            if (!rst_n) stage <= 1'b0;
            else        stage <= fire;
         end
         assign due = stage;
      end else begin : g_chain
         logic [DEPTH-1:0] stages;
         always_ff @(posedge clk) begin
            if (!rst_n) stages <= '0;
            else        stages <= {stages[DEPTH-2:0], fire};
         end
         assign due = stages[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/ddr2_bank_guard.sv
module ddr2_bank_guard
   import ddr2_guard_pkg::*;
#(
   parameter int BANKS       = 4,
   parameter int CLK_PS      = 5000,
   parameter int CL          = 3,
   parameter int AL          = 0,
   parameter bit NEWER_PARTS = 1'b0,
   parameter int TRCD_PS     = 15000,
   parameter int TRP_PS      = 15000,
   parameter int TRC_PS      = 60000,
   parameter int TPREA_PS    = 15000,
   localparam int BW         = $clog2(BANKS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    cmd_op,
   input  logic [BW-1:0] cmd_bank,
   output logic          cmd_legal,
   output logic          viol_sticky,
   output logic [2:0]    viol_code,
   output logic          rd_due,
   output logic          wr_due
);

   localparam int TRAS_PS   = NEWER_PARTS ? 40000 : 45000;
   localparam int RCD_CYC   = ceil_div(TRCD_PS, CLK_PS);
   localparam int RP_CYC    = ceil_div(TRP_PS, CLK_PS);
   localparam int RAS_CYC   = ceil_div(TRAS_PS, CLK_PS);
   localparam int RC_CYC    = ceil_div(TRC_PS, CLK_PS);
   localparam int PREA_CYC  = ceil_div(TPREA_PS, CLK_PS);
   localparam int RCD_POST  = (RCD_CYC - AL > 1) ? RCD_CYC - AL : 1;
   localparam int RCD_LD    = load_of(RCD_POST);
   localparam int RP_LD     = load_of(RP_CYC);
   localparam int RAS_LD    = load_of(RAS_CYC);
   localparam int RC_LD     = load_of(RC_CYC);
   localparam int PREA_LD   = load_of(PREA_CYC);
   localparam int MAX_A     = (RCD_LD > RP_LD) ? RCD_LD : RP_LD;
   localparam int MAX_B     = (RAS_LD > RC_LD) ? RAS_LD : RC_LD;
   localparam int MAX_C     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int MAX_LD    = (MAX_C > PREA_LD) ? MAX_C : PREA_LD;
   localparam int CW        = $clog2(MAX_LD + 2);
   localparam int RL        = AL + CL;
   localparam int WL        = RL - 1;

   // elaboration-time parameter checks
   generate
      if (CL < 3 || CL > 6) begin : g_bad_cl
         $error("ddr2_bank_guard: CL must be 3..6");
      end
      if (AL < 0 || AL > 4) begin : g_bad_al
         $error("ddr2_bank_guard: AL must be 0..4");
      end
      if (BANKS < 2 || (1 << BW) != BANKS) begin : g_bad_banks
         $error("ddr2_bank_guard: BANKS must be a power of two >= 2");
      end
      if (CLK_PS <= 0) begin : g_bad_clk
         $error("ddr2_bank_guard: CLK_PS must be positive");
      end
   endgenerate

   logic [BANKS-1:0] open_vec, rcd_ok_vec, rp_ok_vec, ras_ok_vec, rc_ok_vec;
   logic [BANKS-1:0] act_vec, close_vec;
   logic [CW-1:0]    prea_cnt;
   viol_e            now_code;
   logic             op_act, op_rdwr, op_pre, op_prea;

   assign op_act  = (cmd_op == OP_ACT);
   assign op_rdwr = (cmd_op == OP_RD) || (cmd_op == OP_WR);
   assign op_pre  = (cmd_op == OP_PRE);
   assign op_prea = (cmd_op == OP_PREA);

   // rule evaluation for the presented command
   always_comb begin
      now_code = V_NONE;
      if (op_act) begin
         if (open_vec[cmd_bank])         now_code = V_OPEN;
         else if (prea_cnt != '0)        now_code = V_PREA;
         else if (!rp_ok_vec[cmd_bank])  now_code = V_RP;
         else if (!rc_ok_vec[cmd_bank])  now_code = V_RC;
      end else if (op_rdwr) begin
         if (!open_vec[cmd_bank])        now_code = V_CLOSED;
         else if (!rcd_ok_vec[cmd_bank]) now_code = V_RCD;
      end else if (op_pre) begin
         if (open_vec[cmd_bank] && !ras_ok_vec[cmd_bank]) now_code = V_RAS;
      end else if (op_prea) begin
         if (|(open_vec & ~ras_ok_vec))  now_code = V_RAS;
      end
   end

   assign cmd_legal = (now_code == V_NONE);

   genvar b;
   generate
      for (b = 0; b < BANKS; b++) begin : g_bank
         assign act_vec[b]   = cmd_legal && op_act && (cmd_bank == BW'(b));
         assign close_vec[b] = cmd_legal && open_vec[b] &&
                               (op_prea || (op_pre && (cmd_bank == BW'(b))));
         ddr2_bank_timer #(
            .RCD_LD (RCD_LD),
            .RP_LD  (RP_LD),
            .RAS_LD (RAS_LD),
            .RC_LD  (RC_LD),
            .CW     (CW)
         ) u_timer (
            .clk     (clk),
            .rst_n   (rst_n),
            .act     (act_vec[b]),
            .close   (close_vec[b]),
            .is_open (open_vec[b]),
            .rcd_ok  (rcd_ok_vec[b]),
            .rp_ok   (rp_ok_vec[b]),
            .ras_ok  (ras_ok_vec[b]),
            .rc_ok   (rc_ok_vec[b])
         );
      end
   endgenerate

   // global window after precharge-all
   always_ff @(posedge clk) begin
      if (!rst_n)
         prea_cnt <= '0;
      else if (cmd_legal && op_prea)
         prea_cnt <= CW'(PREA_LD);
      else if (prea_cnt != '0)
         prea_cnt <= prea_cnt - 1'b1;
   end

   // first violation is latched and held
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         viol_sticky <= 1'b0;
         viol_code   <= 3'd0;
      end else if (!viol_sticky && !cmd_legal) begin
         viol_sticky <= 1'b1;
         viol_code   <= now_code;
      end
   end

   ddr2_due_pipe #(.DEPTH(RL)) u_rd_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (cmd_legal && (cmd_op == OP_RD)),
      .due   (rd_due)
   );

   ddr2_due_pipe #(.DEPTH(WL)) u_wr_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (cmd_legal && (cmd_op == OP_WR)),
      .due   (wr_due)
   );

endmodule

// File: rtl/ddr2_bank_guard_chk.sv
module ddr2_bank_guard_chk #(
   parameter int BANKS = 4,
   localparam int BW   = $clog2(BANKS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       cmd_op,
   input logic [BW-1:0]    cmd_bank,
   input logic             cmd_legal,
   input logic             viol_sticky,
   input logic [2:0]       viol_code,
   input logic [BANKS-1:0] open_vec
);

   AST_NOP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == 3'd0) |-> cmd_legal);  // R2

   AST_ACCESS_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_op == 3'd2 || cmd_op == 3'd3) && !open_vec[cmd_bank]) |-> !cmd_legal);  // R3

   AST_ACT_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == 3'd1 && open_vec[cmd_bank]) |-> !cmd_legal);  // R4

   AST_PREA_CLOSES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == 3'd5 && cmd_legal) |=> (open_vec == '0));  // R8

   AST_ILLEGAL_NO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_legal |=> $stable(open_vec));  // R10

   AST_STICKY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_legal |=> viol_sticky);  // R11

   AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      viol_sticky |=> (viol_sticky && $stable(viol_code)));  // R11

   AST_CODE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      viol_sticky |-> (viol_code != 3'd0));  // R11

endmodule

bind ddr2_bank_guard ddr2_bank_guard_chk #(.BANKS(BANKS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_op      (cmd_op),
   .cmd_bank    (cmd_bank),
   .cmd_legal   (cmd_legal),
   .viol_sticky (viol_sticky),
   .viol_code   (viol_code),
   .open_vec    (open_vec)
);

// File: tb/ddr2_bank_guard_test.sv
`timescale 1ns/1ps
module ddr2_bank_guard_test;

   localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                          PRE = 3'd4, PREA = 3'd5;
   // R9: 5000 ps period, newer parts, CL=3, AL=1
   localparam int RL = 4;
   localparam int WL = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cmd_op = NOP;
   logic [1:0] cmd_bank = 2'd0;
   logic       cmd_legal, viol_sticky, rd_due, wr_due;
   logic [2:0] viol_code;

   int compared = 0;
   int mismatched = 0;
   int cyc = 0;
   int rdq[$];
   int wrq[$];
   bit done = 1'b0;

   always #4 clk = ~clk;

   ddr2_bank_guard #(.NEWER_PARTS(1'b1), .CL(3), .AL(1)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
      .cmd_legal(cmd_legal), .viol_sticky(viol_sticky), .viol_code(viol_code),
      .rd_due(rd_due), .wr_due(wr_due)
   );

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   task automatic chk(input int act_v, input int exp_v, input string req, input string what);
      compared++;
      if (act_v != exp_v) begin
         mismatched++;
         $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act_v, exp_v, cyc);
      end
   endtask

   // scoreboard monitor for data strobes (R12)
   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_due) begin
            if (rdq.size() == 0) chk(1, 0, "R12", "unexpected rd_due");
            else chk(cyc, rdq.pop_front(), "R12", "rd_due cycle");
         end else if (rdq.size() > 0 && rdq[0] <= cyc) begin
            chk(0, 1, "R12", "missing rd_due");
            void'(rdq.pop_front());
         end
         if (wr_due) begin
            if (wrq.size() == 0) chk(1, 0, "R12", "unexpected wr_due");
            else chk(cyc, wrq.pop_front(), "R12", "wr_due cycle");
         end else if (wrq.size() > 0 && wrq[0] <= cyc) begin
            chk(0, 1, "R12", "missing wr_due");
            void'(wrq.pop_front());
         end
      end
   end

   task automatic issue(input logic [2:0] op, input logic [1:0] bk,
                        input bit exp_legal, input string req);
      @(negedge clk);
      cmd_op = op;
      cmd_bank = bk;
      #1;
      chk(cmd_legal, exp_legal, req, "cmd_legal");
      if (exp_legal && op == RD) rdq.push_back(cyc + RL);
      if (exp_legal && op == WR) wrq.push_back(cyc + WL);
      @(posedge clk);
      #1;
      cmd_op = NOP;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) issue(NOP, 2'd0, 1'b1, "R2");
   endtask

   task automatic expect_viol(input int code, input string req);
      chk(viol_sticky, 1, req, "viol_sticky");
      chk(viol_code, code, req, "viol_code");
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cmd_op = NOP;
      rdq.delete();
      wrq.delete();
      repeat (2) @(negedge clk);
      chk(viol_sticky, 0, "R1", "viol_sticky in reset");
      chk(viol_code, 0, "R1", "viol_code in reset");
      chk(rd_due, 0, "R1", "rd_due in reset");
      chk(wr_due, 0, "R1", "wr_due in reset");
      rst_n = 1'b1;
   endtask

   initial begin
      do_reset();
      // legal flow
      issue(ACT, 2'd0, 1'b1, "R1");      // c0, bank closed after reset
      idle(1);
      issue(RD, 2'd0, 1'b1, "R3");       // c2 posted-CAS gap 2
      issue(WR, 2'd0, 1'b1, "R3");       // c3
      issue(ACT, 2'd1, 1'b1, "R7");      // c4 other bank
      issue(3'd6, 2'd0, 1'b1, "R2");     // c5 reserved code acts as NOP
      idle(2);
      issue(PRE, 2'd0, 1'b1, "R5");      // c8 tRAS=8 met (R9)
      issue(PRE, 2'd2, 1'b1, "R5");      // c9 closed bank
      idle(2);
      issue(ACT, 2'd0, 1'b1, "R7");      // c12 tRC=12 met
      idle(7);
      issue(PREA, 2'd0, 1'b1, "R8");     // c20
      idle(2);
      issue(ACT, 2'd3, 1'b1, "R8");      // c23 tPREA=3 met
      issue(ACT, 2'd2, 1'b1, "R5");      // bank 2 still closed
      idle(6);
      chk(viol_sticky, 0, "R11", "no violation on legal flow");

      // R3 timing
      do_reset();
      issue(ACT, 2'd0, 1'b1, "R3");
      issue(RD, 2'd0, 1'b0, "R3");
      expect_viol(1, "R3");
      idle(6);                           // R10: no rd_due from illegal READ

      // R3 closed bank
      do_reset();
      issue(WR, 2'd2, 1'b0, "R3");
      expect_viol(6, "R3");
      idle(4);

      // R4
      do_reset();
      issue(ACT, 2'd1, 1'b1, "R4");
      idle(1);
      issue(ACT, 2'd1, 1'b0, "R4");
      expect_viol(7, "R4");

      // R5 / R9 / R10 / R11
      do_reset();
      issue(ACT, 2'd0, 1'b1, "R5");
      idle(6);
      issue(PRE, 2'd0, 1'b0, "R9");      // c7, one short of tRAS
      expect_viol(3, "R5");
      issue(PRE, 2'd0, 1'b1, "R10");     // bank stayed open, now legal
      issue(PRE, 2'd0, 1'b1, "R5");      // bank closed now; no effect
      issue(RD, 2'd0, 1'b0, "R10");
      expect_viol(3, "R11");             // first code held

      // R6 (priority over tRC)
      do_reset();
      issue(ACT, 2'd0, 1'b1, "R6");
      idle(7);
      issue(PRE, 2'd0, 1'b1, "R6");      // c8
      idle(1);
      issue(ACT, 2'd0, 1'b0, "R6");      // c10
      expect_viol(2, "R6");

      // R7
      do_reset();
      issue(ACT, 2'd0, 1'b1, "R7");
      idle(7);
      issue(PRE, 2'd0, 1'b1, "R7");      // c8
      idle(2);
      issue(ACT, 2'd0, 1'b0, "R7");      // c11
      expect_viol(4, "R7");

      // R8 window
      do_reset();
      issue(ACT, 2'd0, 1'b1, "R8");
      idle(7);
      issue(PREA, 2'd0, 1'b1, "R8");     // c8
      idle(1);
      issue(ACT, 2'd1, 1'b0, "R8");      // c10
      expect_viol(5, "R8");

      // R8 tRAS on precharge-all
      do_reset();
      issue(ACT, 2'd0, 1'b1, "R8");
      issue(PREA, 2'd0, 1'b0, "R8");
      expect_viol(3, "R8");

      idle(2);
      chk(rdq.size() + wrq.size(), 0, "R12", "strobes left pending");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule